// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a circular list of transmit descriptors held in system memory. It feeds the buffer that each descriptor points to into a MAC as a stream of bytes. A descriptor takes two 32-bit words. The first word carries a 16-bit status half and a 16-bit byte count. The second word carries the address of the buffer. Software owns a descriptor until it sets the ready flag in that descriptor. The engine hands the descriptor back by writing its first word again with the ready flag cleared.

The engine sits idle in a halted state after reset. It also halts whenever it fetches a descriptor that is not ready. Software restarts it with a one-cycle clear-halt pulse. A ring-init pulse, given while the engine is halted, moves the fetch pointer to the programmed base address.

A graceful stop request lets the frame in flight finish, then holds the engine still and reports completion with a one-cycle pulse. The engine resumes when the request is withdrawn. Memory traffic uses a single word-wide request/acknowledge master. Bytes leave on a valid/ready stream that also carries an end-of-frame marker and a flag asking the MAC to append the FCS.

Top module: `txbd_ring_engine`

## Requirements
- R1: Descriptor word 0 holds status in bits 31:16 and byte count in bits 15:0, and word 1 (at +4) holds the byte address of the buffer. The engine emits exactly that many bytes from the buffer, in ascending address order. Within a memory word, the byte at the lowest address is in bits 31:24.
- R2: Once a descriptor is finished, word 0 is written back with status bit 15 (ready) cleared. All other status bits and the byte count are kept unchanged.
- R3: A descriptor whose status bit 13 (wrap) is set is the last one in the ring, so the next fetch is at the base address. Without the wrap bit, the next descriptor sits 8 bytes further on.
- R4: After reset the engine is halted and drives neither the stream nor memory. Fetching a descriptor with bit 15 clear halts it with no write-back and no bytes sent. A clear-halt pulse re-fetches that same descriptor.
- R5: A ring-init pulse while halted loads the fetch pointer from the base-address input.
- R6: tx_last is high only on the final byte of a descriptor whose status bit 11 (last) is set. tx_crc follows status bit 10 on every byte of that descriptor.
- R7: A descriptor whose status bit 12 (interrupt) is set produces exactly one one-cycle tx_event pulse after its write-back. Other descriptors produce none.
- R8: A ready descriptor with a byte count of zero sends no bytes. It is written back with ready cleared and status bit 0 (error) set, and the ring advances past it.
- R9: While gstop_req is high, the engine completes the frame in progress (descriptors up to one with the last bit) and then fetches nothing more. It pulses stop_done once, also when the request arrives while halted, and continues when the request drops.
- R10: mem_req, mem_addr and mem_we stay unchanged until mem_ack. tx_valid, tx_data and tx_last stay unchanged until tx_ready.
- R11: Buffer addresses need no word alignment; the first byte comes from the addressed lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_base | input | AW | Byte address of the first descriptor |
| ring_init | input | 1 | Load fetch pointer from ring_base (honoured while halted) |
| clr_halt | input | 1 | One-cycle pulse that leaves the halted state |
| gstop_req | input | 1 | Graceful stop request, level |
| halted | output | 1 | Engine is halted |
| stop_done | output | 1 | One-cycle graceful stop completion pulse |
| tx_event | output | 1 | One-cycle completion pulse for descriptors with the interrupt bit |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Word-aligned memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | MAC accepts byte |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_crc | output | 1 | MAC should append FCS for this frame |

## Verification
The bench fills rings with random byte counts, buffer offsets and flag mixes. Memory latency and MAC back-pressure are random throughout, so the byte stream and the write-backs are tested under stalls.

Rings come in two kinds. In one, every descriptor is ready and the ring wraps back onto its own cleared first entry. In the other, a non-ready entry appears part-way through. Re-arming the entry the engine halted on separates a correct wrap to the base address from a linear walk, and it also shows that the refetch happens at the halt point.

Two bases used in turn show that ring-init loads the pointer. A frame split across descriptors, with a stop raised in its first buffer, shows the difference between stopping at a frame boundary and stopping at a descriptor boundary.

// File: rtl/txbd_ring_engine.sv
module txbd_ring_engine #(
  parameter int AW         = 16,
  parameter int DESC_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  input  logic          ring_init,
  input  logic          clr_halt,
  input  logic          gstop_req,
  output logic          halted,
  output logic          stop_done,
  output logic          tx_event,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          tx_crc
);

  localparam int B_RDY  = 15;
  localparam int B_WRAP = 13;
  localparam int B_INT  = 12;
  localparam int B_LAST = 11;
  localparam int B_CRC  = 10;
  localparam logic [15:0] RDY_MASK = 16'(1 << B_RDY);
  localparam logic [AW-1:0] STEP   = AW'(DESC_BYTES);

  typedef enum logic [2:0] {S_HALT, S_IDLE, S_RD0, S_RD1, S_DRD, S_EMIT, S_WB} st_t;

  st_t          state;
  logic [AW-1:0] dptr, cur;
  logic [15:0]  bstat, blen, rem;
  logic [31:0]  wbuf;
  logic         in_frame, gs_stopped;
  logic         zlen;

  assign halted   = (state == S_HALT);
  assign mem_req  = (state == S_RD0) || (state == S_RD1) || (state == S_DRD) || (state == S_WB);
  assign mem_we   = (state == S_WB);
  assign zlen     = (blen == 16'd0);
  assign mem_wdata = {(bstat & ~RDY_MASK) | {15'd0, zlen}, blen};
  assign tx_valid = (state == S_EMIT);
  assign tx_last  = bstat[B_LAST] && (rem == 16'd1);
  assign tx_crc   = bstat[B_CRC];

  always_comb begin
    case (state)
      S_RD1:   mem_addr = dptr + AW'(4);
      S_DRD:   mem_addr = {cur[AW-1:2], 2'b00};
      default: mem_addr = dptr;
    endcase
  end

  always_comb begin
    case (cur[1:0])
      2'd0:    tx_data = wbuf[31:24];
      2'd1:    tx_data = wbuf[23:16];
      2'd2:    tx_data = wbuf[15:8];
      default: tx_data = wbuf[7:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_HALT;
      dptr       <= '0;
      cur        <= '0;
      bstat      <= '0;
      blen       <= '0;
      rem        <= '0;
      wbuf       <= '0;
      in_frame   <= 1'b0;
      gs_stopped <= 1'b0;
      stop_done  <= 1'b0;
      tx_event   <= 1'b0;
    end else begin
      stop_done <= 1'b0;
      tx_event  <= 1'b0;
      if (!gstop_req) gs_stopped <= 1'b0;
      case (state)
        S_HALT: begin
          if (ring_init) dptr <= ring_base;
          if (gstop_req && !gs_stopped) begin
            gs_stopped <= 1'b1;
            stop_done  <= 1'b1;
          end
          if (clr_halt) state <= S_IDLE;
        end
        S_IDLE: begin
          if (gstop_req && !in_frame) begin
            if (!gs_stopped) begin
              gs_stopped <= 1'b1;
              stop_done  <= 1'b1;
            end
          end else begin
            state <= S_RD0;
          end
        end
        S_RD0: if (mem_ack) begin
          bstat <= mem_rdata[31:16];
          blen  <= mem_rdata[15:0];
          rem   <= mem_rdata[15:0];
          if (!mem_rdata[16+B_RDY])          state <= S_HALT;
          else if (mem_rdata[15:0] == 16'd0) state <= S_WB;
          else                               state <= S_RD1;
        end
        S_RD1: if (mem_ack) begin
          cur   <= mem_rdata[AW-1:0];
          state <= S_DRD;
        end
        S_DRD: if (mem_ack) begin
          wbuf  <= mem_rdata;
          state <= S_EMIT;
        end
        S_EMIT: if (tx_ready) begin
          cur <= cur + AW'(1);
          rem <= rem - 16'd1;
          if (rem == 16'd1)          state <= S_WB;
          else if (cur[1:0] == 2'd3) state <= S_DRD;
        end
        S_WB: if (mem_ack) begin
          tx_event <= bstat[B_INT];
          if (!zlen) in_frame <= !bstat[B_LAST];
          dptr  <= bstat[B_WRAP] ? ring_base : dptr + STEP;
          state <= S_IDLE;
        end
        default: state <= S_HALT;
      endcase
    end
  end

endmodule

// File: rtl/txbd_ring_engine_chk.sv
module txbd_ring_engine_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_halt,
  input logic          halted,
  input logic          stop_done,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ack,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_last
);

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R10
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R10
  AST_WB_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[31]); // R2
  AST_ZERO_LEN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && (mem_wdata[15:0] == 16'd0) |-> mem_wdata[16]); // R8
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !tx_valid && !mem_req); // R4
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !clr_halt |=> halted); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |=> !stop_done); // R9
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |-> !tx_valid && !mem_req); // R9

endmodule

bind txbd_ring_engine txbd_ring_engine_chk #(.AW(AW)) u_chk (.*);

// File: tb/txbd_ring_engine_bench.sv
module txbd_ring_engine_bench;
  localparam int AW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [AW-1:0] ring_base = '0;
  logic          ring_init = 1'b0, clr_halt = 1'b0, gstop_req = 1'b0;
  logic          halted, stop_done, tx_event;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = '0;
  logic          mem_ack = 1'b0;
  logic          tx_valid, tx_last, tx_crc;
  logic          tx_ready = 1'b0;
  logic [7:0]    tx_data;

  txbd_ring_engine #(.AW(AW)) u_txbd_ring_engine (.*);

  logic [31:0] mem_w [0:255];
  int wait_cnt = 0;
  int tests = 0, fails = 0;
  int nbytes = 0, nev = 0, ndone = 0, exp_ev = 0;
  logic [9:0]  expq[$];
  logic [31:0] exp_wb [0:7];
  logic [31:0] orig_w [0:7];

  always @(posedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (wait_cnt == 0) begin
        mem_ack <= 1'b1;
        if (mem_we) mem_w[mem_addr[9:2]] <= mem_wdata;
        else        mem_rdata <= mem_w[mem_addr[9:2]];
        wait_cnt <= int'($urandom % 3);
      end else wait_cnt <= wait_cnt - 1;
    end
    tx_ready <= ($urandom % 4) != 0;
  end

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (tx_valid && tx_ready) begin
      nbytes++;
      if (expq.size() == 0) check(1'b0, "R1 unexpected byte", {tx_crc, tx_last, tx_data}, 0);
      else begin
        logic [9:0] e;
        e = expq.pop_front();
        check({tx_crc, tx_last, tx_data} == e, "R1/R6/R11 byte {crc,last,data}",
              {tx_crc, tx_last, tx_data}, e);
      end
    end
    if (tx_event) nev++;
    if (stop_done) ndone++;
  end

  function automatic logic [31:0] wb_expect(input logic [15:0] st, input int len);
    return {(st & 16'h7fff) | {15'd0, len == 0}, 16'(len)};
  endfunction

  task automatic put_desc(input int base, input int idx, input bit rdy, input bit wrp,
                          input bit lst, input bit crc, input bit intr, input int len, input int off);
    logic [15:0] st;
    int ba;
    st = 16'(($urandom % 512) << 1);
    st[15] = rdy; st[13] = wrp; st[12] = intr; st[11] = lst; st[10] = crc;
    ba = 'h200 + idx * 24 + off;
    mem_w[(base + idx * 8) >> 2]     = {st, 16'(len)};
    mem_w[(base + idx * 8 + 4) >> 2] = 32'(ba);
    orig_w[idx] = {st, 16'(len)};
    exp_wb[idx] = wb_expect(st, len);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      int a;
      b = 8'($urandom);
      a = ba + i;
      mem_w[a >> 2][8 * (3 - (a % 4)) +: 8] = b;
      if (rdy) expq.push_back({crc, lst && (i == len - 1), b});
    end
    if (rdy && intr) exp_ev++;
  endtask

  task automatic pulse_init(input int base);
    @(negedge clk); ring_base = AW'(base); ring_init = 1'b1;
    @(negedge clk); ring_init = 1'b0;
  endtask

  task automatic run_until_halt();
    @(negedge clk); clr_halt = 1'b1;
    @(negedge clk); clr_halt = 1'b0;
    for (int i = 0; i < 20000 && !halted; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_ring(input int base, input int k, input string tag);
    for (int i = 0; i < k; i++)
      check(mem_w[(base + i * 8) >> 2] == exp_wb[i], tag, mem_w[(base + i * 8) >> 2], exp_wb[i]);
    check(expq.size() == 0, "R1 all bytes sent", expq.size(), 0);
    check(nev == exp_ev, "R7 event count", nev, exp_ev);
    check(halted == 1'b1, "R4 halted at non-ready", halted, 1);
  endtask

  task automatic rand_round(input int r);
    int base, k, m, len;
    bit wrap_all;
    base = (r % 2 == 0) ? 'h000 : 'h080;
    k = 3 + int'($urandom % 5);
    wrap_all = (r % 2 == 1);
    m = wrap_all ? k : int'($urandom % k);
    for (int i = 0; i < k; i++) begin
      len = ($urandom % 5 == 0) ? 0 : 1 + int'($urandom % 16);
      put_desc(base, i, i < m, i == k - 1, $urandom % 2, $urandom % 2, $urandom % 2,
               len, int'($urandom % 4));
    end
    for (int i = m; i < k; i++) exp_wb[i] = orig_w[i];
    pulse_init(base);
    run_until_halt();
    check_ring(base, k, "R2/R8/R4 write-back after first pass (R5 base)");
    if (wrap_all) begin
      put_desc(base, 0, 1, 0, 1, $urandom % 2, 1, 1 + int'($urandom % 12), int'($urandom % 4));
      run_until_halt();
      check(mem_w[base >> 2] == exp_wb[0], "R3 wrap refetches base", mem_w[base >> 2], exp_wb[0]);
      check_ring(base, k, "R3 ring after wrap");
    end else begin
      put_desc(base, m, 1, m == k - 1, 1, $urandom % 2, $urandom % 2, 1 + int'($urandom % 12),
               int'($urandom % 4));
      run_until_halt();
      check(mem_w[(base + m * 8) >> 2] == exp_wb[m], "R4 refetch halted descriptor",
            mem_w[(base + m * 8) >> 2], exp_wb[m]);
      check_ring(base, k, "R4 ring after refetch");
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem_w[i] = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(halted == 1'b1, "R4 reset halted", halted, 1);
    check(tx_valid == 1'b0 && mem_req == 1'b0, "R4 reset quiet", {tx_valid, mem_req}, 0);

    put_desc('h000, 0, 1, 0, 1, 1, 1, 0, 0);
    put_desc('h000, 1, 1, 0, 1, 0, 0, 3, 3);
    put_desc('h000, 2, 0, 1, 1, 0, 0, 2, 0);
    exp_wb[2] = orig_w[2];
    pulse_init('h000);
    run_until_halt();
    check(mem_w[0] == exp_wb[0], "R8 zero length write-back", mem_w[0], exp_wb[0]);
    check_ring('h000, 3, "R2 directed write-back");

    for (int r = 0; r < 6; r++) rand_round(r);

    put_desc('h080, 0, 1, 0, 0, 1, 0, 6, 1);
    put_desc('h080, 1, 1, 0, 1, 1, 1, 5, 2);
    put_desc('h080, 2, 1, 0, 1, 0, 0, 4, 0);
    put_desc('h080, 3, 0, 1, 1, 0, 0, 2, 0);
    pulse_init('h080);
    ndone = 0;
    begin
      int nb0;
      nb0 = nbytes;
      @(negedge clk); clr_halt = 1'b1;
      @(negedge clk); clr_halt = 1'b0;
      for (int i = 0; i < 5000 && nbytes == nb0; i++) @(negedge clk);
      gstop_req = 1'b1;
      for (int i = 0; i < 5000 && ndone == 0; i++) @(negedge clk);
      repeat (50) @(negedge clk);
    end
    check(ndone == 1, "R9 one stop pulse", ndone, 1);
    check(expq.size() == 4, "R9 frame finished, next held", expq.size(), 4);
    check(mem_w[('h080 + 16) >> 2][31] == 1'b1, "R9 next descriptor untouched",
          mem_w[('h080 + 16) >> 2][31], 1);
    check(halted == 1'b0, "R9 stopped not halted", halted, 0);
    gstop_req = 1'b0;
    for (int i = 0; i < 20000 && !halted; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R9 resumes after release", expq.size(), 0);
    check(nev == exp_ev, "R7 event count after stop", nev, exp_ev);
    gstop_req = 1'b1;
    repeat (5) @(negedge clk);
    check(ndone == 2, "R9 stop while halted", ndone, 2);
    gstop_req = 1'b0;
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(1_800_000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule